// File: doc/BRIEF.md
# DMA Controller Register Bank and Interrupt Unit

This block is the control and status slave of a multi-channel DMA controller. Software reaches it through a simple word-addressed read/write port that spans a 4 KB window. It holds a global configuration word and a sync word. For each channel it holds five words: source, destination, link pointer, control and configuration. It also keeps the raw terminal-count and raw error flags for every channel. The channel engine sets those flags through pulse inputs, and software clears them by writing ones.

Each channel's configuration word carries two enable bits. These enable bits mask the raw flags into the status views and into three level interrupt outputs. The block also returns a fixed set of identification bytes. When software writes a channel configuration word or the global configuration word, a one-cycle pulse tells the channel engine to look at its registers again. The data movement itself lives in the channel engine, not here.

The port carries a word address, which is the byte offset divided by four. A read of a 32-bit word is presented on `regRdata` in the cycle after it was requested. The number of channels is a parameter and may be 2 or 8.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every register, every raw flag and every mask is zero, so all reads return 0 and `irqTc`, `irqErr`, `irqAny` and `cfgWritten` are low.
- R2: The word at byte offset 0x100 + 32*c + 4*w is channel c's word w, with w=0 source, w=1 destination, w=2 link pointer, w=3 control and w=4 configuration. All five words are written and read back in full. Words w=5..7 read 0 and writing them has no effect.
- R3: An access to a channel index c at or above NCH reads 0. A write to such a channel changes no register and gives no `cfgWritten` pulse.
- R4: A 1 on `tcSet[c]` or `errSet[c]` sets the raw terminal-count or raw error flag of channel c. Reading offset 0x14 returns the raw terminal-count flags, and offset 0x18 returns the raw error flags, with channel c at bit c.
- R5: Writing offset 0x08 clears each raw terminal-count flag whose data bit is 1, and writing offset 0x10 does the same for the raw error flags. If a set and a clear of the same flag happen in the same cycle, the set wins.
- R6: The terminal-count mask of channel c is bit 15 of its configuration word, and the error mask is bit 14. Offset 0x04 reads raw TC AND mask, offset 0x0C reads raw error AND mask, and offset 0x00 reads the OR of those two.
- R7: Offset 0x1C reads, at bit c, bit 0 of channel c's configuration word.
- R8: `irqTc` is the OR over channels of masked terminal-count, `irqErr` is the OR of masked error, and `irqAny` is `irqTc` OR `irqErr`. Each output follows a state change one clock later.
- R9: The global configuration word at offset 0x30 and the sync word at offset 0x34 store and return all 32 bits.
- R10: Offsets 0xFE0 to 0xFFC return one identification byte per word in bits 7:0, with the upper bits 0. In order the bytes are 0x81 (NCH=2) or 0x80 (NCH=8), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05 and 0xB1.
- R11: The software request words at offsets 0x20 to 0x2C read 0, and writes to them change nothing. Any other undecoded offset also reads 0.
- R12: `cfgWritten` is high for exactly the one cycle after a write to an existing channel's configuration word or to the global configuration word. No other write raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register access in this cycle |
| regWrite | input | 1 | 1 for a write, 0 for a read |
| regWordAddr | input | 10 | Word address, which is the byte offset divided by four |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after a read |
| tcSet | input | NCH | Terminal-count set pulses from the channel engine |
| errSet | input | NCH | Error set pulses from the channel engine |
| irqTc | output | 1 | Masked terminal-count interrupt |
| irqErr | output | 1 | Masked error interrupt |
| irqAny | output | 1 | OR of the two interrupts |
| cfgWritten | output | 1 | One-cycle pulse after a configuration write |

## Verification
The hardest case to reach from the ports is a set and a clear of the same raw flag landing on the same clock edge. The bench produces it by raising `tcSet` in the very cycle it issues the clear write, and then reads the raw word to confirm the flag survived. Telling raw flags apart from masked flags is the other subtle point. For that, the two channels are given different mask bits, so that the raw, masked and combined views and the interrupt pins all carry different values at the same time.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int DATA_W      = 32;
  localparam int WADDR_W     = 10;
  localparam int CH_WORDS    = 5;
  localparam int CFG_WORD    = 4;
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_ERRM_BIT = 14;
  localparam int CFG_TCM_BIT = 15;
  localparam int ID_BYTES    = 8;

  // global word indices (byte offset / 4)
  localparam logic [3:0] G_STAT_ALL = 4'd0;
  localparam logic [3:0] G_STAT_TC  = 4'd1;
  localparam logic [3:0] G_CLR_TC   = 4'd2;
  localparam logic [3:0] G_STAT_ERR = 4'd3;
  localparam logic [3:0] G_CLR_ERR  = 4'd4;
  localparam logic [3:0] G_RAW_TC   = 4'd5;
  localparam logic [3:0] G_RAW_ERR  = 4'd6;
  localparam logic [3:0] G_ENABLED  = 4'd7;
  localparam logic [3:0] G_CONFIG   = 4'd12;
  localparam logic [3:0] G_SYNC     = 4'd13;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_CHAN   = 2'd1,
    RD_GLOBAL = 2'd2,
    RD_IDENT  = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic       chWe;
    logic [2:0] chIdx;
    logic [2:0] chWord;
    logic       glbCfgWe;
    logic       syncWe;
    logic       tcClrWe;
    logic       errClrWe;
    logic       rdEn;
    rdKind_e    rdKind;
    logic [2:0] rdChan;
    logic [3:0] rdSub;
  } strobe_t;
endpackage

// File: rtl/dma_regbank_ctrl.sv
module dma_regbank_ctrl
  import dma_regbank_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic               regSel,
  input  logic               regWrite,
  input  logic [WADDR_W-1:0] regWordAddr,
  output strobe_t            strb
);
  logic       chanWin;
  logic       chanOk;
  logic       identWin;
  logic       glbWin;
  logic [2:0] chIdx;
  logic [2:0] chWord;
  logic [3:0] glbWord;
  logic       wrAcc;

  always_comb begin
    chIdx    = regWordAddr[5:3];
    chWord   = regWordAddr[2:0];
    glbWord  = regWordAddr[3:0];
    chanWin  = (regWordAddr[9:6] == 4'h1);
    chanOk   = chanWin && (int'(chIdx) < NCH);
    identWin = (regWordAddr[9:3] == 7'h7F);
    glbWin   = (regWordAddr[9:4] == 6'h00);
    wrAcc    = regSel && regWrite;
  end

  always_comb begin
    strb          = '0;
    strb.chIdx    = chIdx;
    strb.chWord   = chWord;
    strb.chWe     = wrAcc && chanOk && (int'(chWord) < CH_WORDS);
    strb.glbCfgWe = wrAcc && glbWin && (glbWord == G_CONFIG);
    strb.syncWe   = wrAcc && glbWin && (glbWord == G_SYNC);
    strb.tcClrWe  = wrAcc && glbWin && (glbWord == G_CLR_TC);
    strb.errClrWe = wrAcc && glbWin && (glbWord == G_CLR_ERR);
    strb.rdEn     = regSel && !regWrite;
    strb.rdChan   = chIdx;
    if (chanOk) begin
      strb.rdKind = RD_CHAN;
      strb.rdSub  = {1'b0, chWord};
    end else if (identWin) begin
      strb.rdKind = RD_IDENT;
      strb.rdSub  = {1'b0, regWordAddr[2:0]};
    end else if (glbWin) begin
      strb.rdKind = RD_GLOBAL;
      strb.rdSub  = glbWord;
    end else begin
      strb.rdKind = RD_ZERO;
      strb.rdSub  = '0;
    end
  end
endmodule

// File: rtl/dma_regbank_chan.sv
module dma_regbank_chan
  import dma_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [2:0]        wrWord,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        rdWord,
  output logic [DATA_W-1:0] rdVal,
  output logic              tcMask,
  output logic              errMask,
  output logic              enBit
);
  logic [DATA_W-1:0] words [CH_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CH_WORDS; i++) words[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < CH_WORDS; i++)
        if (int'(wrWord) == i) words[i] <= wdata;
    end
  end

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < CH_WORDS; i++)
      if (int'(rdWord) == i) rdVal = words[i];
  end

  assign tcMask  = words[CFG_WORD][CFG_TCM_BIT];
  assign errMask = words[CFG_WORD][CFG_ERRM_BIT];
  assign enBit   = words[CFG_WORD][CFG_EN_BIT];
endmodule

// File: rtl/dma_regbank_dpath.sv
module dma_regbank_dpath
  import dma_regbank_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCH-1:0]    tcSet,
  input  logic [NCH-1:0]    errSet,
  output logic [DATA_W-1:0] rdata,
  output logic              irqTc,
  output logic              irqErr,
  output logic              irqAny,
  output logic              cfgWritten
);
  localparam int PAD_W = DATA_W - NCH;
  localparam logic [7:0] ID_FIRST = (NCH == 2) ? 8'h81 : 8'h80;

  logic [DATA_W-1:0] chRd [NCH];
  logic [NCH-1:0]    tcMask, errMask, enBits;
  logic [NCH-1:0]    rawTc, rawErr;
  logic [NCH-1:0]    tcClrBits, errClrBits;
  logic [NCH-1:0]    maskedTc, maskedErr;
  logic [DATA_W-1:0] glbCfg, syncWord;
  logic [DATA_W-1:0] rdNext, chSel, glbSel;
  logic [7:0]        idByte;
  logic              cfgHit;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic chWeC;
    assign chWeC = strb.chWe && (int'(strb.chIdx) == c);
    dma_regbank_chan u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .we     (chWeC),
      .wrWord (strb.chWord),
      .wdata  (wdata),
      .rdWord (strb.rdSub[2:0]),
      .rdVal  (chRd[c]),
      .tcMask (tcMask[c]),
      .errMask(errMask[c]),
      .enBit  (enBits[c])
    );
  end

  // raw flags: clear by writing ones, a set in the same cycle wins
  assign tcClrBits  = strb.tcClrWe  ? wdata[NCH-1:0] : '0;
  assign errClrBits = strb.errClrWe ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawTc  <= '0;
      rawErr <= '0;
    end else begin
      rawTc  <= (rawTc  & ~tcClrBits)  | tcSet;
      rawErr <= (rawErr & ~errClrBits) | errSet;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      glbCfg   <= '0;
      syncWord <= '0;
    end else begin
      if (strb.glbCfgWe) glbCfg   <= wdata;
      if (strb.syncWe)   syncWord <= wdata;
    end
  end

  assign maskedTc  = rawTc  & tcMask;
  assign maskedErr = rawErr & errMask;

  // read path
  always_comb begin
    chSel = '0;
    for (int c = 0; c < NCH; c++)
      if (int'(strb.rdChan) == c) chSel = chRd[c];
  end

  always_comb begin
    unique case (strb.rdSub)
      G_STAT_ALL: glbSel = {{PAD_W{1'b0}}, maskedTc | maskedErr};
      G_STAT_TC:  glbSel = {{PAD_W{1'b0}}, maskedTc};
      G_STAT_ERR: glbSel = {{PAD_W{1'b0}}, maskedErr};
      G_RAW_TC:   glbSel = {{PAD_W{1'b0}}, rawTc};
      G_RAW_ERR:  glbSel = {{PAD_W{1'b0}}, rawErr};
      G_ENABLED:  glbSel = {{PAD_W{1'b0}}, enBits};
      G_CONFIG:   glbSel = glbCfg;
      G_SYNC:     glbSel = syncWord;
      default:    glbSel = '0;
    endcase
  end

  always_comb begin
    case (strb.rdSub[2:0])
      3'd0:    idByte = ID_FIRST;
      3'd1:    idByte = 8'h10;
      3'd2:    idByte = 8'h04;
      3'd3:    idByte = 8'h0A;
      3'd4:    idByte = 8'h0D;
      3'd5:    idByte = 8'hF0;
      3'd6:    idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  end

  always_comb begin
    case (strb.rdKind)
      RD_CHAN:   rdNext = chSel;
      RD_GLOBAL: rdNext = glbSel;
      RD_IDENT:  rdNext = {{(DATA_W-8){1'b0}}, idByte};
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdata <= '0;
    else if (strb.rdEn) rdata <= rdNext;
  end

  // registered outputs
  assign cfgHit = strb.glbCfgWe || (strb.chWe && (int'(strb.chWord) == CFG_WORD));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqTc      <= 1'b0;
      irqErr     <= 1'b0;
      irqAny     <= 1'b0;
      cfgWritten <= 1'b0;
    end else begin
      irqTc      <= |maskedTc;
      irqErr     <= |maskedErr;
      irqAny     <= |(maskedTc | maskedErr);
      cfgWritten <= cfgHit;
    end
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regSel,
  input  logic               regWrite,
  input  logic [WADDR_W-1:0] regWordAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NCH-1:0]     tcSet,
  input  logic [NCH-1:0]     errSet,
  output logic               irqTc,
  output logic               irqErr,
  output logic               irqAny,
  output logic               cfgWritten
);
  strobe_t strb;

  dma_regbank_ctrl #(.NCH(NCH)) u_ctrl (
    .regSel     (regSel),
    .regWrite   (regWrite),
    .regWordAddr(regWordAddr),
    .strb       (strb)
  );

  dma_regbank_dpath #(.NCH(NCH)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (regWdata),
    .tcSet     (tcSet),
    .errSet    (errSet),
    .rdata     (regRdata),
    .irqTc     (irqTc),
    .irqErr    (irqErr),
    .irqAny    (irqAny),
    .cfgWritten(cfgWritten)
  );
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int NCH = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        regSel,
  input logic        regWrite,
  input logic [7:0]  wAddrHi,
  input logic [31:0] regRdata,
  input logic [NCH-1:0] tcSet,
  input logic        irqTc,
  input logic        irqErr,
  input logic        irqAny,
  input logic        cfgWritten
);
  assert_any_is_or_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqAny == (irqTc || irqErr));

  assert_tc_rise_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqTc) |-> $past((|tcSet) || (regSel && regWrite), 2));

  assert_tc_fall_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqTc) |-> $past(regSel && regWrite, 2));

  assert_cfg_pulse_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    cfgWritten |-> $past(regSel && regWrite));

  assert_ident_upper_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWrite && wAddrHi[7:1] == 7'h7F) |=> (regRdata[31:8] == 24'h0));

  assert_softreq_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWrite && wAddrHi == 8'h02) |=> (regRdata == 32'h0));
endmodule

bind dma_regbank dma_regbank_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regSel    (regSel),
  .regWrite  (regWrite),
  .wAddrHi   (regWordAddr[9:2]),
  .regRdata  (regRdata),
  .tcSet     (tcSet),
  .irqTc     (irqTc),
  .irqErr    (irqErr),
  .irqAny    (irqAny),
  .cfgWritten(cfgWritten)
);

// File: tb/dma_regbank_tb.sv
`timescale 1ns/1ps
module dma_regbank_tb;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        regWrite = 1'b0;
  logic [9:0]  regWordAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NCH-1:0] tcSet = '0;
  logic [NCH-1:0] errSet = '0;
  logic        irqTc, irqErr, irqAny, cfgWritten;

  always #4 clk = ~clk;

  dma_regbank #(.NCH(NCH)) u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regWordAddr(regWordAddr), .regWdata(regWdata), .regRdata(regRdata),
    .tcSet(tcSet), .errSet(errSet), .irqTc(irqTc), .irqErr(irqErr),
    .irqAny(irqAny), .cfgWritten(cfgWritten)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];

  int total = 0;
  int bad = 0;
  logic rdPend = 1'b0;
  logic pulseSeen;
  bit   finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the queued expectation
  always @(posedge clk) begin
    if (rdPend) begin
      #2;
      if (expQ.size() == 0) check("read without expectation", 32'h1, 32'h0);
      else begin
        item_t it;
        it = expQ.pop_front();
        check(it.tag, regRdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [11:0] off, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    regSel = 1'b1; regWrite = 1'b0; regWordAddr = off[11:2]; rdPend = 1'b1;
    @(negedge clk);
    regSel = 1'b0; rdPend = 1'b0;
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] val);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regWordAddr = off[11:2]; regWdata = val;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0;
    pulseSeen = cfgWritten;
  endtask

  task automatic pulseSet(input logic [NCH-1:0] t, input logic [NCH-1:0] e);
    @(negedge clk);
    tcSet = t; errSet = e;
    @(negedge clk);
    tcSet = '0; errSet = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] ids [8];
    ids[0] = 8'h81; ids[1] = 8'h10; ids[2] = 8'h04; ids[3] = 8'h0A;
    ids[4] = 8'h0D; ids[5] = 8'hF0; ids[6] = 8'h05; ids[7] = 8'hB1;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irqAny after reset", {31'b0, irqAny}, 32'h0);
    check("R1 cfgWritten after reset", {31'b0, cfgWritten}, 32'h0);
    rd(12'h100, 32'h0, "R1 ch0 source reset");
    rd(12'h130, 32'h0, "R1 ch1 config reset");
    rd(12'h030, 32'h0, "R1 global config reset");
    rd(12'h014, 32'h0, "R1 raw TC reset");

    // R2 channel words
    wr(12'h100, 32'h1111_2222);
    check("R12 no pulse on source write", {31'b0, pulseSeen}, 32'h0);
    wr(12'h104, 32'h3333_4444);
    wr(12'h108, 32'h5555_6660);
    wr(12'h10C, 32'h8000_0ABC);
    wr(12'h110, 32'h0000_4001);
    check("R12 pulse on ch0 config write", {31'b0, pulseSeen}, 32'h1);
    @(negedge clk);
    check("R12 pulse lasts one cycle", {31'b0, cfgWritten}, 32'h0);
    wr(12'h130, 32'h0000_8000);
    wr(12'h134, 32'hFFFF_FFFF);
    rd(12'h100, 32'h1111_2222, "R2 ch0 source");
    rd(12'h104, 32'h3333_4444, "R2 ch0 destination");
    rd(12'h108, 32'h5555_6660, "R2 ch0 link");
    rd(12'h10C, 32'h8000_0ABC, "R2 ch0 control");
    rd(12'h110, 32'h0000_4001, "R2 ch0 config");
    rd(12'h130, 32'h0000_8000, "R2 ch1 config");
    rd(12'h134, 32'h0, "R2 ch1 word5 reads zero");

    // R3 channel beyond count
    wr(12'h140, 32'hDEAD_BEEF);
    wr(12'h150, 32'h0000_C001);
    check("R3 no pulse for absent channel config", {31'b0, pulseSeen}, 32'h0);
    rd(12'h140, 32'h0, "R3 absent channel source");
    rd(12'h150, 32'h0, "R3 absent channel config");
    rd(12'h100, 32'h1111_2222, "R3 ch0 source untouched");
    rd(12'h01C, 32'h1, "R3 enabled map unchanged");

    // R7 enabled bitmap
    rd(12'h01C, 32'h1, "R7 enabled bitmap");

    // R4 R6 R8 raw and masked
    pulseSet(2'b11, 2'b00);
    check("R8 irqTc lags state by one clock", {31'b0, irqTc}, 32'h0);
    @(negedge clk);
    check("R8 irqTc high", {31'b0, irqTc}, 32'h1);
    check("R8 irqAny high", {31'b0, irqAny}, 32'h1);
    check("R8 irqErr low", {31'b0, irqErr}, 32'h0);
    rd(12'h014, 32'h3, "R4 raw TC");
    rd(12'h004, 32'h2, "R6 masked TC");
    rd(12'h00C, 32'h0, "R6 masked error empty");
    rd(12'h000, 32'h2, "R6 combined");
    pulseSet(2'b00, 2'b11);
    @(negedge clk);
    check("R8 irqErr high", {31'b0, irqErr}, 32'h1);
    rd(12'h018, 32'h3, "R4 raw error");
    rd(12'h00C, 32'h1, "R6 masked error");
    rd(12'h000, 32'h3, "R6 combined both");

    // R5 write one to clear
    wr(12'h008, 32'h0000_0002);
    @(negedge clk);
    check("R8 irqTc low after clear", {31'b0, irqTc}, 32'h0);
    rd(12'h014, 32'h1, "R5 raw TC after clear");
    rd(12'h004, 32'h0, "R5 masked TC after clear");
    wr(12'h010, 32'h0000_0001);
    @(negedge clk);
    check("R8 irqErr low after clear", {31'b0, irqErr}, 32'h0);
    check("R8 irqAny low after clears", {31'b0, irqAny}, 32'h0);
    rd(12'h018, 32'h2, "R5 raw error after clear");

    // R5 set wins over clear in the same cycle
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regWordAddr = 10'h002; regWdata = 32'h3;
    tcSet = 2'b01;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0; tcSet = '0;
    rd(12'h014, 32'h1, "R5 set wins over clear");
    wr(12'h008, 32'h1);
    rd(12'h014, 32'h0, "R5 cleared afterwards");

    // R9 global config and sync
    wr(12'h030, 32'hA5A5_0001);
    check("R12 pulse on global config write", {31'b0, pulseSeen}, 32'h1);
    wr(12'h034, 32'h1234_5678);
    check("R12 no pulse on sync write", {31'b0, pulseSeen}, 32'h0);
    rd(12'h030, 32'hA5A5_0001, "R9 global config");
    rd(12'h034, 32'h1234_5678, "R9 sync");

    // R10 identification
    for (int i = 0; i < 8; i++)
      rd(12'hFE0 + 12'(i * 4), {24'h0, ids[i]}, "R10 ident byte");

    // R11 software request words and undecoded offsets
    for (int i = 0; i < 4; i++) wr(12'h020 + 12'(i * 4), 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) rd(12'h020 + 12'(i * 4), 32'h0, "R11 soft request reads zero");
    rd(12'h030, 32'hA5A5_0001, "R11 config untouched by soft writes");
    rd(12'h014, 32'h0, "R11 raw TC untouched by soft writes");
    rd(12'h200, 32'h0, "R11 undecoded offset 0x200");
    rd(12'h03C, 32'h0, "R11 undecoded global word 15");
    rd(12'h800, 32'h0, "R11 undecoded offset 0x800");

    repeat (3) @(negedge clk);
    check("queue drained", expQ.size(), 32'h0);
    finish_run();
  end
endmodule